// File: doc/BRIEF.md
# Chained Group CSR Access Unit

This unit is the control-register front end of a core. Rather than having every register compare its own address against each request, the registers sit in three ordered groups linked as a chain. A request carries a 12-bit register address, an operation and a data word. It is accepted into the first group. If none of that group's registers owns the address, the request moves one register stage down the chain on the next clock. Each group decodes only its own small address window. The frequently touched counter and status registers go in the first group. Floating-point control, scratch and debug registers go further down.

The cost is latency that depends on where the register lives. The first group answers one cycle after acceptance, the second after two and the third after three. An address that no group owns falls out of the chain one cycle after the third group and is answered with an illegal flag. Only one request is in flight at a time. A request is taken on a valid/ready handshake and a response is returned on a valid/ready handshake. Set and clear requests are read-modify-write operations inside the owning group. Every response returns the value the register held before the operation.

Top module: `csr_chain`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and every register holds zero.
- R2: A request accepted (`req_valid` and `req_ready` high at a clock edge) for an address in 0xB00–0xB03 (group 1) raises `rsp_valid` in the cycle that follows that edge, with `rsp_illegal` low.
- R3: A request for 0x340–0x343 (group 2) is answered two cycles after acceptance, and one for 0x7C0–0x7C3 (group 3) three cycles after, with `rsp_valid` low in the cycles before.
- R4: A request for any other address is answered four cycles after acceptance with `rsp_illegal` high and `rsp_rdata` zero, and it changes no register.
- R5: Operation code 2'b00 (read) returns the register value and leaves the register unchanged.
- R6: Operation code 2'b01 (write) returns the old value and then replaces the register with `req_wdata`.
- R7: Operation code 2'b10 (set) returns the old value and then ORs `req_wdata` into the register.
- R8: Operation code 2'b11 (clear) returns the old value and then clears the register bits that are 1 in `req_wdata`.
- R9: `req_ready` is low from the edge that accepts a request until the edge where its response is taken (`rsp_valid` and `rsp_ready` high). It is high again in the cycle after that edge.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid with unchanged data and flag. A register update happens only at the edge where the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, can take a request |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| req_wdata | input | 32 | Write / mask data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Register value before the operation |
| rsp_illegal | output | 1 | No group owns the address |

## Verification
The bench targets the window edges, such as 0xB03 against 0xB04 and 0x33F against 0x340. A decoder with an off-by-one error would claim a neighbour's address, or would drop a valid one into the illegal path. Such a fault changes the response cycle, so it shows up as a latency mismatch. Responses are held back while `rsp_ready` is low to catch a design that commits a write before the hand-off or applies it on every stalled cycle. Either fault corrupts the value that a later read returns. Writes to unowned addresses are followed by reads of real registers, which exposes a chain whose last group still writes on a miss. Requests are issued on the first cycle `req_ready` returns, so a ready signal that rises one cycle early or late is caught.

// File: rtl/csr_chain_pkg.sv
package csr_chain_pkg;

    localparam int NUM_GRP = 3;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

endpackage

// File: rtl/csr_chain_grp.sv
module csr_chain_grp
    import csr_chain_pkg::*;
#(
    parameter int                ADDR_W = 12,
    parameter int                DATA_W = 32,
    parameter int                NREG   = 4,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [ADDR_W-1:0] addr,
    input  csr_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
    } grp_state_t;

    grp_state_t        q, d;
    logic [ADDR_W-1:0] off;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] cur;

    always_comb begin
        off   = addr - BASE;
        idx   = off[IDX_W-1:0];
        hit   = active && (addr >= BASE) && (off < ADDR_W'(NREG));
        cur   = q.regs[idx];
        rdata = hit ? cur : '0;
        d     = q;
        if (commit && hit) begin
            unique case (op)
                OP_READ:  d.regs[idx] = cur;
                OP_WRITE: d.regs[idx] = wdata;
                OP_SET:   d.regs[idx] = cur | wdata;
                OP_CLEAR: d.regs[idx] = cur & ~wdata;
                default:  d.regs[idx] = cur;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/csr_chain.sv
module csr_chain
    import csr_chain_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter int                DATA_W  = 32,
    parameter int                NREG    = 4,
    parameter logic [ADDR_W-1:0] G1_BASE = 12'hB00,
    parameter logic [ADDR_W-1:0] G2_BASE = 12'h340,
    parameter logic [ADDR_W-1:0] G3_BASE = 12'h7C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_illegal
);
    localparam logic [NUM_GRP-1:0][ADDR_W-1:0] BASES = {G3_BASE, G2_BASE, G1_BASE};

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        csr_op_e           op;
    } stage_t;

    typedef struct packed {
        stage_t [NUM_GRP-1:0] stg;
        logic                 illeg;
        logic [DATA_W-1:0]    wdata;
    } chain_state_t;

    chain_state_t                    q, d;
    logic [NUM_GRP-1:0]              grp_hit;
    logic [NUM_GRP-1:0]              grp_commit;
    logic [NUM_GRP-1:0][DATA_W-1:0]  grp_rdata;
    logic                            fire;
    logic                            busy;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        csr_chain_grp #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .NREG   (NREG),
            .BASE   (BASES[g])
        ) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (q.stg[g].vld),
            .addr   (q.stg[g].addr),
            .op     (q.stg[g].op),
            .wdata  (q.wdata),
            .commit (grp_commit[g]),
            .hit    (grp_hit[g]),
            .rdata  (grp_rdata[g])
        );
    end

    always_comb begin
        d         = q;
        busy      = q.illeg;
        rsp_rdata = '0;
        for (int k = 0; k < NUM_GRP; k++) begin
            busy      = busy | q.stg[k].vld;
            rsp_rdata = rsp_rdata | grp_rdata[k];
        end
        rsp_valid   = (|grp_hit) | q.illeg;
        rsp_illegal = q.illeg;
        req_ready   = !busy;
        fire        = rsp_valid && rsp_ready;
        grp_commit  = fire ? grp_hit : '0;

        // forward misses one group down the chain
        for (int k = 0; k < NUM_GRP; k++) begin
            if (q.stg[k].vld && !grp_hit[k]) begin
                d.stg[k].vld = 1'b0;
                if (k == NUM_GRP - 1) d.illeg = 1'b1;
                else                  d.stg[k+1] = q.stg[k];
            end
        end

        if (fire) begin
            d.illeg = 1'b0;
            for (int k = 0; k < NUM_GRP; k++) d.stg[k].vld = 1'b0;
        end

        if (req_valid && req_ready) begin
            d.stg[0].vld  = 1'b1;
            d.stg[0].addr = req_addr;
            d.stg[0].op   = csr_op_e'(req_op);
            d.wdata       = req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/csr_chain_chk.sv
module csr_chain_chk #(
    parameter int                ADDR_W  = 12,
    parameter int                DATA_W  = 32,
    parameter int                NREG    = 4,
    parameter logic [ADDR_W-1:0] G1_BASE = 12'hB00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_illegal
);
    logic acc;
    logic acc_g1;
    assign acc    = req_valid && req_ready;
    assign acc_g1 = acc && (req_addr >= G1_BASE) && (req_addr < G1_BASE + ADDR_W'(NREG));

    assert_g1_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_g1 |=> (rsp_valid && !rsp_illegal));

    assert_illegal_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (rsp_valid && rsp_rdata == '0));

    assert_busy_when_answering_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready);

    assert_ready_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> req_ready);

    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_rdata) && $stable(rsp_illegal)));

endmodule

bind csr_chain csr_chain_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NREG    (NREG),
    .G1_BASE (G1_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_rdata   (rsp_rdata),
    .rsp_illegal (rsp_illegal)
);

// File: tb/csr_chain_bench.sv
`timescale 1ns/1ps
module csr_chain_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_rdata;
    logic        rsp_illegal;

    always #4 clk = ~clk;

    csr_chain u_csr_chain (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_op(req_op), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    logic [31:0] mdl [int];
    bit          pend = 0;
    int          wt = 0;
    int          p_addr = 0;
    logic [1:0]  p_op = '0;
    logic [31:0] p_wd = '0;
    bit          stalled = 0;

    function automatic int lat_of(int a);
        if (a >= 'hB00 && a <= 'hB03) return 1;
        if (a >= 'h340 && a <= 'h343) return 2;
        if (a >= 'h7C0 && a <= 'h7C3) return 3;
        return 4;
    endfunction

    function automatic logic [31:0] mval(int a);
        if (mdl.exists(a)) return mdl[a];
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (time %0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            pend = 0; wt = 0; stalled = 0;
        end else if (pend) begin
            if (wt == 0) begin
                stalled = !rsp_ready;
                if (rsp_ready) begin
                    if (lat_of(p_addr) != 4) begin
                        case (p_op)
                            2'b01: mdl[p_addr] = p_wd;
                            2'b10: mdl[p_addr] = mval(p_addr) | p_wd;
                            2'b11: mdl[p_addr] = mval(p_addr) & ~p_wd;
                            default: ;
                        endcase
                    end
                    pend = 0;
                end
            end else begin
                wt = wt - 1;
            end
        end else if (req_valid) begin
            pend = 1; p_addr = int'(req_addr); p_op = req_op; p_wd = req_wdata;
            wt = lat_of(p_addr) - 1; stalled = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic int    l = lat_of(p_addr);
            automatic string lt = (l == 1) ? "R2" : (l == 4) ? "R4" : "R3";
            automatic string ot;
            automatic logic  ev = pend && (wt == 0);
            case (p_op)
                2'b00: ot = "R5";
                2'b01: ot = "R6";
                2'b10: ot = "R7";
                default: ot = "R8";
            endcase
            check("R9 req_ready", {31'b0, req_ready}, {31'b0, !pend});
            check({lt, " rsp_valid timing"}, {31'b0, rsp_valid}, {31'b0, ev});
            if (ev) begin
                check({lt, " rsp_illegal"}, {31'b0, rsp_illegal}, {31'b0, (l == 4)});
                check(stalled ? {"R10 held rdata (", ot, ")"} : {ot, " rsp_rdata"},
                      rsp_rdata, (l == 4) ? 32'h0 : mval(p_addr));
            end
        end
    end

    task automatic do_op(int a, logic [1:0] op, logic [31:0] wd, int hold);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = 12'(a); req_op = op; req_wdata = wd;
        rsp_ready = (hold == 0);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (hold) @(negedge clk);
        rsp_ready = 1'b1;
        while (pend) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        automatic int addrs[16] = '{'hB00, 'hB01, 'hB02, 'hB03, 'h340, 'h341, 'h342, 'h343,
                                    'h7C0, 'h7C1, 'h7C2, 'h7C3, 'hB04, 'h33F, 'h7C4, 'h000};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset req_ready", {31'b0, req_ready}, 32'h1);
        check("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        // R1: every register reads zero after reset
        for (int i = 0; i < 12; i++) do_op(addrs[i], 2'b00, 32'h0, 0);
        // R6 write, R5 readback per group
        do_op('hB01, 2'b01, 32'hDEAD_BEEF, 0);
        do_op('hB01, 2'b00, 32'h0, 0);
        do_op('h342, 2'b01, 32'h0F0F_0000, 0);
        do_op('h342, 2'b10, 32'h0000_00FF, 0);   // R7
        do_op('h342, 2'b00, 32'h0, 0);
        do_op('h7C3, 2'b01, 32'hFFFF_FFFF, 0);
        do_op('h7C3, 2'b11, 32'h00FF_00FF, 0);   // R8
        do_op('h7C3, 2'b00, 32'h0, 0);
        // R4 window edges and ignored writes
        do_op('hB04, 2'b01, 32'h1234_5678, 0);
        do_op('h33F, 2'b10, 32'hFFFF_FFFF, 0);
        do_op('h7C4, 2'b01, 32'hAAAA_AAAA, 0);
        do_op('hB03, 2'b00, 32'h0, 0);
        do_op('h343, 2'b00, 32'h0, 0);
        do_op('h7C0, 2'b00, 32'h0, 0);
        // R10 stalled responses, single commit
        do_op('hB00, 2'b10, 32'h0000_0011, 5);
        do_op('hB00, 2'b10, 32'h0000_0100, 3);
        do_op('hB00, 2'b00, 32'h0, 0);
        do_op('h7C1, 2'b01, 32'h5555_0000, 6);
        do_op('h7C1, 2'b00, 32'h0, 2);
        do_op('h123, 2'b01, 32'h1, 7);
        // mixed traffic
        for (int n = 0; n < 300; n++) begin
            automatic int a = addrs[$urandom_range(0, 15)];
            do_op(a, 2'($urandom_range(0, 3)), $urandom(), $urandom_range(0, 3));
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule